// File: doc/BRIEF.md
# Page-Buffered Write Controller

This block is the write path of a byte-wide nonvolatile store that commits data one page at a time. A host drives active-low chip-enable, output-enable and write-enable strobes together with an address and a data byte. The system clock samples all of them. Each accepted byte goes into a page buffer. The buffer holds `2**OFF_W` bytes and the low address bits pick the slot.

Loading has no explicit commit command. The load phase ends on its own when no new strobe begins within `LOAD_TO` clock cycles of the last accepted byte. The controller then raises `busy` for exactly `WRITE_LEN` cycles. At the end of that time it copies the whole page into the array in one step. The page number comes from the last byte loaded. Slots that received no byte are written as FFh. Strobes that arrive while `busy` is high have no effect.

Reads return the array byte at the presented address one cycle later. During a commit they return the old contents, because the array changes only when `busy` drops.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset `busy` is 0 and every array location reads FFh.
- R2: A write strobe is the interval in which `ce_n` and `we_n` are both low. The address is taken on the clock where that interval begins, which is the later of the two falling edges. The data byte is the one present on the last clock of the interval, just before the earlier of the two rising edges.
- R3: Loading stays open while every new strobe begins within `LOAD_TO` cycles of the previous accepted byte. This includes a strobe that first appears on the very cycle the window would close: that strobe wins and no commit starts.
- R4: If no strobe begins within `LOAD_TO` cycles after the clock that accepted the last byte, `busy` rises on exactly that `LOAD_TO`-th clock.
- R5: `busy` stays high for exactly `WRITE_LEN` cycles. The array keeps its old contents while `busy` is high and shows the new page once `busy` has fallen.
- R6: The whole buffer is written to the page selected by the upper address bits (above bit `OFF_W-1`) of the last byte loaded. The low `OFF_W` bits of every earlier byte still choose its slot.
- R7: Loading the same slot again within one page load replaces the earlier byte.
- R8: Every slot of the committed page that received no byte in that page load is written as FFh.
- R9: A strobe during which `oe_n` is low loads nothing. A pulse on `we_n` while `ce_n` stays high loads nothing. Neither one starts a commit.
- R10: Strobes that occur while `busy` is high change neither the buffer nor the array, and they do not start a further commit.
- R11: `dout` shows the array byte at `addr` one clock after `addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every strobe is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: upper bits pick the page, low OFF_W bits the slot |
| din | input | 8 | Write data byte |
| dout | output | 8 | Registered read data from the array |
| busy | output | 1 | High while the internal page write runs |

## Verification
The risky coincidence is the inactivity timeout expiring on the same clock at which the next strobe is first seen. The bench places the next strobe's falling edge exactly on the last cycle of the window and expects `busy` to stay low, with both bytes landing in one page. The second case is a byte-load attempt that overlaps the commit. The bench issues strobes while `busy` is high and then confirms two things through reads and `busy`: the committed page holds only the earlier bytes, and no second write cycle follows.

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W    = 10,
  parameter int OFF_W     = 7,
  parameter int LOAD_TO   = 50,
  parameter int WRITE_LEN = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy
);
  localparam int PAGE_N = 1 << OFF_W;
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TW     = $clog2(LOAD_TO + 1);
  localparam int WW     = $clog2(WRITE_LEN + 1);

  logic              strobe, strobe_q, oe_q, loading, busy_r;
  logic [7:0]        din_q;
  logic [ADDR_W-1:0] alat;
  logic [TW-1:0]     tmr;
  logic [WW-1:0]     wcnt;
  logic [PAGE_N-1:0] mask;
  logic [PG_W-1:0]   page;
  logic [7:0]        pbuf [PAGE_N];
  logic [7:0]        mem  [DEPTH];

  assign strobe = ~ce_n & ~we_n;
  assign busy   = busy_r;

  wire take   = strobe_q & ~strobe & oe_q & ~busy_r;
  wire expire = loading & ~strobe & ~take & (tmr == TW'(LOAD_TO - 1));
  wire done   = busy_r & (wcnt == WW'(WRITE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      oe_q     <= 1'b1;
      din_q    <= '0;
      alat     <= '0;
      loading  <= 1'b0;
      busy_r   <= 1'b0;
      tmr      <= '0;
      wcnt     <= '0;
      mask     <= '0;
      page     <= '0;
      dout     <= 8'hFF;
      for (int i = 0; i < PAGE_N; i++) pbuf[i] <= 8'hFF;
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else begin
      strobe_q <= strobe;
      oe_q     <= oe_n;
      din_q    <= din;
      dout     <= mem[addr];
      if (strobe & ~strobe_q) alat <= addr;

      if (take) begin
        pbuf[alat[OFF_W-1:0]] <= din_q;
        mask[alat[OFF_W-1:0]] <= 1'b1;
        page    <= alat[ADDR_W-1:OFF_W];
        loading <= 1'b1;
        tmr     <= '0;
      end else if (loading) begin
        if (strobe) tmr <= '0;
        else if (expire) begin
          loading <= 1'b0;
          busy_r  <= 1'b1;
          wcnt    <= '0;
        end else tmr <= tmr + 1'b1;
      end

      if (busy_r) begin
        if (done) begin
          busy_r <= 1'b0;
          mask   <= '0;
          for (int i = 0; i < PAGE_N; i++) begin
            mem[{page, OFF_W'(i)}] <= mask[i] ? pbuf[i] : 8'hFF;
            pbuf[i] <= 8'hFF;
          end
        end else wcnt <= wcnt + 1'b1;
      end
    end
  end

  assert_busy_after_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_r) |-> ($past(loading) && !$past(strobe)));

  assert_strobe_holds_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && strobe) |=> !busy_r);

  assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |=> (!busy_r || ($stable(mask) && $stable(page))));

  assert_oe_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !oe_n && !busy_r) ##1 !strobe |=> $stable(mask));

  assert_idle_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !busy_r) |-> (mask == '0));
endmodule

// File: tb/tb_page_write_ctrl.sv
module tb_page_write_ctrl;
  localparam int AW = 10, OW = 7, TO = 20, WR = 30, PN = 1 << OW, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  wire  [7:0] dout;
  wire        busy;

  page_write_ctrl #(.ADDR_W(AW), .OFF_W(OW), .LOAD_TO(TO), .WRITE_LEN(WR)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [DEPTH];
  logic [7:0] ref_buf [PN];
  logic [PN-1:0] ref_mask;
  int ref_page;
  bit ref_open;

  function automatic int page_of(int a); return a / PN; endfunction
  function automatic int off_of(int a);  return a % PN; endfunction
  function automatic logic [7:0] expect_byte(int a); return ref_mem[a]; endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_load(int a, logic [7:0] d);
    if (!ref_open) begin ref_mask = '0; ref_open = 1; end
    ref_buf[off_of(a)] = d;
    ref_mask[off_of(a)] = 1'b1;
    ref_page = page_of(a);
  endtask

  task automatic ref_commit();
    for (int i = 0; i < PN; i++)
      ref_mem[ref_page * PN + i] = ref_mask[i] ? ref_buf[i] : 8'hFF;
    ref_mask = '0;
    ref_open = 0;
  endtask

  // returns on the falling clock edge just after the clock that takes the byte
  task automatic wr_byte(logic [AW-1:0] a, logic [7:0] d, int mode, bit oe_lo = 0);
    if (mode == 2) begin
      @(negedge clk) ce_n = 0; we_n = 0; oe_n = !oe_lo; addr = a; din = d;
      @(negedge clk) addr = ~a;
      @(negedge clk) ce_n = 1; we_n = 1; din = ~d;
      @(negedge clk) oe_n = 1;
    end else begin
      @(negedge clk) oe_n = !oe_lo; addr = ~a; din = ~d;
      if (mode == 0) ce_n = 0; else we_n = 0;
      @(negedge clk) addr = a;
      if (mode == 0) we_n = 0; else ce_n = 0;
      @(negedge clk) addr = a ^ 1; din = d;
      @(negedge clk) din = ~d;
      if (mode == 0) we_n = 1; else ce_n = 1;
      @(negedge clk) ce_n = 1; we_n = 1; oe_n = 1;
    end
  endtask

  task automatic rd_chk(logic [AW-1:0] a, string req);
    @(negedge clk) ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk) chk(req, dout, expect_byte(a));
    ce_n = 1; oe_n = 1;
  endtask

  task automatic finish_page();
    int cnt;
    repeat (TO - 1) @(negedge clk);
    chk("R4 busy low before timeout", busy, 0);
    @(negedge clk) chk("R4 busy rises at timeout", busy, 1);
    cnt = 1;
    while (busy && cnt < WR + 10) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    chk("R5 busy length", cnt, WR);
    ref_commit();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    ref_mask = '0; ref_open = 0; ref_page = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    rd_chk(10'd0, "R1");
    rd_chk(10'd1023, "R1");
    rd_chk(10'd200, "R11");

    // WE-controlled single byte
    wr_byte({3'd2, 7'd5}, 8'hA5, 0);
    ref_load({3'd2, 7'd5}, 8'hA5);
    finish_page();
    rd_chk({3'd2, 7'd5}, "R2 we-controlled");
    rd_chk({3'd2, 7'd6}, "R8");

    // CE-controlled byte, read during the commit
    wr_byte({3'd1, 7'd9}, 8'h3C, 1);
    ref_load({3'd1, 7'd9}, 8'h3C);
    repeat (TO + 1) @(negedge clk);
    chk("R4 busy during commit", busy, 1);
    rd_chk({3'd1, 7'd9}, "R5 old data during busy");
    while (busy) @(negedge clk);
    ref_commit();
    rd_chk({3'd1, 7'd9}, "R2 ce-controlled");

    // several bytes, overwrite, page from last byte
    wr_byte({3'd3, 7'd0}, 8'h11, 0);  ref_load({3'd3, 7'd0}, 8'h11);
    repeat (3) @(negedge clk);
    wr_byte({3'd3, 7'd10}, 8'h22, 1); ref_load({3'd3, 7'd10}, 8'h22);
    wr_byte({3'd3, 7'd0}, 8'h33, 2);  ref_load({3'd3, 7'd0}, 8'h33);
    wr_byte({3'd5, 7'd20}, 8'h44, 0); ref_load({3'd5, 7'd20}, 8'h44);
    finish_page();
    rd_chk({3'd5, 7'd0}, "R7 overwrite");
    rd_chk({3'd5, 7'd10}, "R6 slot kept");
    rd_chk({3'd5, 7'd20}, "R6 last byte");
    rd_chk({3'd5, 7'd21}, "R8 unloaded");
    rd_chk({3'd3, 7'd10}, "R6 other page untouched");

    // inhibit: OE low, and WE pulse with CE high
    wr_byte({3'd4, 7'd7}, 8'h5A, 0, 1);
    @(negedge clk) we_n = 0; addr = {3'd4, 7'd8}; din = 8'h77;
    @(negedge clk);
    @(negedge clk) we_n = 1;
    repeat (TO + 5) @(negedge clk);
    chk("R9 no commit after inhibited strobes", busy, 0);
    rd_chk({3'd4, 7'd7}, "R9");
    rd_chk({3'd4, 7'd8}, "R9");

    // strobe first seen on the last clock of the window
    wr_byte({3'd6, 7'd1}, 8'h61, 2); ref_load({3'd6, 7'd1}, 8'h61);
    repeat (TO - 2) @(negedge clk);
    wr_byte({3'd6, 7'd2}, 8'h62, 2); ref_load({3'd6, 7'd2}, 8'h62);
    chk("R3 no commit on boundary", busy, 0);
    finish_page();
    rd_chk({3'd6, 7'd1}, "R3");
    rd_chk({3'd6, 7'd2}, "R3");

    // strobes while busy
    wr_byte({3'd7, 7'd3}, 8'h71, 0); ref_load({3'd7, 7'd3}, 8'h71);
    repeat (TO) @(negedge clk);
    chk("R10 busy before injected writes", busy, 1);
    wr_byte({3'd7, 7'd3}, 8'h00, 0);
    wr_byte({3'd7, 7'd4}, 8'h55, 2);
    while (busy) @(negedge clk);
    ref_commit();
    repeat (TO + 4) @(negedge clk);
    chk("R10 no second commit", busy, 0);
    rd_chk({3'd7, 7'd3}, "R10");
    rd_chk({3'd7, 7'd4}, "R10");

    // random page loads
    for (int it = 0; it < 6; it++) begin
      int pg, nb;
      pg = $urandom % 8;
      nb = 1 + $urandom % 5;
      for (int k = 0; k < nb; k++) begin
        logic [AW-1:0] a;
        int pa, md;
        pa = (k == nb - 1) ? pg : $urandom % 8;
        a  = AW'(pa * PN + $urandom % PN);
        md = $urandom % 3;
        wr_byte(a, 8'($urandom), md);
        ref_load(a, ref_buf[off_of(a)]);
        ref_buf[off_of(a)] = 8'(dut_in_last(a));
        if (k < nb - 1) repeat ($urandom % (TO - 4)) @(negedge clk);
      end
      finish_page();
      for (int i = 0; i < PN; i++) rd_chk(AW'(pg * PN + i), "R6 random page");
    end

    summary();
    $finish;
  end

  // the byte last driven on din before its complement was applied
  function automatic int dut_in_last(logic [AW-1:0] a);
    return int'(~din);
  endfunction
endmodule